// File: doc/BRIEF.md
# 16-bit Timer/Event Counter with One-Shot Pulse

This block is a 16-bit up-counter for general timing work. It has two 16-bit compare registers, a pulse output, two match interrupt strobes and a sticky overflow flag. The counter advances by one on every clock in which the count-enable strobe is high and the block is running. A 2-bit mode field sets how it behaves. The block can be stopped, it can count freely, it can wrap on a match with compare register 0, or it can restart on a selected edge of the trigger input.

A one-shot option produces a single pulse on the output. A software trigger bit or the trigger edge starts it. The trigger clears the counter. The output goes high on the count step that matches compare register 1 and goes low on the step that matches compare register 0. Triggers that arrive during a pulse are dropped. A capture option copies the running count into compare register 1 on a chosen edge of the capture input. Both external inputs pass through a synchronizer and an edge detector. They are ignored while the block is stopped.

Software reaches the block through a small register port. Writes take effect on the clock edge. Reads return data one cycle after the read strobe. Address 0 is the control register. Address 1 is the counter, which is read-only. Address 2 is compare register 0 and address 3 is compare register 1. The control register holds the following fields:

- bits [1:0]: mode
- bits [3:2]: trigger edge select
- bits [5:4]: capture edge select
- bit 6: one-shot enable
- bit 7: capture enable
- bit 8: overflow flag on read; writing 1 clears it
- bit 9: software trigger; writing 1 starts a pulse; reads as 0

Top module: `evt_timer16`

## Requirements
- R1: After reset, the control register, the counter, both compare registers, `tmr_out`, both interrupts and `ovf_flag` are 0. In mode 00 (stopped) the counter is held at 0 whatever `count_en` does.
- R2: In mode 01 (free-running) the counter goes up by one on each clock in which `count_en` is high. It runs past the value of compare register 0 without wrapping.
- R3: In mode 10 (match-clear) a count step taken while the counter equals compare register 0 loads 0 instead of the next value. `irq_cmp0` is high for exactly one cycle, in the cycle after that step. The period is therefore compare-0 + 1 steps.
- R4: A count step from FFFFH to 0000H sets `ovf_flag`. This holds in free-running mode. It also holds in match-clear mode when compare register 0 holds FFFFH.
- R5: Writing 1 to control bit 8 clears the overflow flag, with two exceptions. A clear written after an overflow step and before the next count step is dropped. A hardware set in the same cycle as a clear also wins.
- R6: In mode 11 (edge-clear) a valid edge on `trig_in` clears the counter. The edge is chosen by control bits [3:2]: 00 falling, 01 rising, 10 no edge, 11 both edges.
- R7: A write to control bits [3:2] or [5:4] takes effect only while the mode currently held is 00. Otherwise those bits keep their old value.
- R8: When control bit 6 is set in mode 01 or 11, a software trigger or a valid trigger edge does three things. It clears the counter, `tmr_out` rises after the step that matches compare register 1, and `tmr_out` falls after the step that matches compare register 0. With `count_en` held high the pulse lasts compare-0 minus compare-1 cycles. The compare-1 match raises `irq_cmp1` for one cycle.
- R9: A software trigger or trigger edge that arrives while a one-shot pulse is pending or high is ignored. The pulse width does not change.
- R10: In mode 10, one-shot requests have no effect and `tmr_out` stays low.
- R11: With control bit 7 set, a valid edge on `cap_in` copies the counter into compare register 1. The edge is chosen by control bits [5:4], using the same encoding as R6.
- R12: Reading the counter at address 1 never changes compare register 1.
- R13: If a capture and a read of address 3 fall in the same cycle, the captured value is stored. That read returns the parameter value `RD_CONFLICT_VAL`, which is 0 by default.
- R14: While the mode is 00, edges on `trig_in` and `cap_in` are not accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid one cycle after `bus_re` |
| count_en | input | 1 | Count step strobe from the prescaler |
| trig_in | input | 1 | Asynchronous trigger input |
| cap_in | input | 1 | Asynchronous capture input |
| tmr_out | output | 1 | One-shot pulse output |
| irq_cmp0 | output | 1 | One-cycle strobe after a compare-0 match step |
| irq_cmp1 | output | 1 | One-cycle strobe after a compare-1 match step |
| ovf_flag | output | 1 | Sticky overflow flag |

## Verification
Most wrong internal states show at the ports within one count step. A counter that wraps at the wrong value moves the `irq_cmp0` period at the next match. A one-shot state machine that accepts a retrigger resets the counter, so the `tmr_out` high time comes out longer. A hold bit that is lost lets a clear through at once, and the next read of the control register shows bit 8 low. Capture and edge-select faults show within three clocks of the input edge, because the synchronizer adds that latency. They appear in the next read of the counter or of compare register 1.

// File: rtl/evt_timer16_pkg.sv
package evt_timer16_pkg;

   typedef enum logic [1:0] {
      MODE_STOP  = 2'b00,
      MODE_FREE  = 2'b01,
      MODE_MATCH = 2'b10,
      MODE_EDGE  = 2'b11
   } tmr_mode_e;

   typedef enum logic [1:0] {
      EDGE_FALL = 2'b00,
      EDGE_RISE = 2'b01,
      EDGE_NONE = 2'b10,
      EDGE_BOTH = 2'b11
   } edge_sel_e;

   localparam logic [1:0] REG_CTRL = 2'd0;
   localparam logic [1:0] REG_CNT  = 2'd1;
   localparam logic [1:0] REG_CMP0 = 2'd2;
   localparam logic [1:0] REG_CMP1 = 2'd3;

   localparam int CB_MODE_LO = 0;
   localparam int CB_TSEL_LO = 2;
   localparam int CB_CSEL_LO = 4;
   localparam int CB_OS_EN   = 6;
   localparam int CB_CAP_EN  = 7;
   localparam int CB_OVF     = 8;
   localparam int CB_SWTRIG  = 9;
   localparam int CTRL_BITS  = 10;

endpackage

// File: rtl/evt_edge_det.sv
module evt_edge_det
   import evt_timer16_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      din,
   input  edge_sel_e sel,
   input  logic      enable,
   output logic      edge_hit
);

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("evt_edge_det: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   prev_q;
   logic                   cur;
   logic                   rise;
   logic                   fall;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= '0;
         prev_q <= 1'b0;
      end else begin
         sync_q <= {sync_q[SYNC_STAGES-2:0], din};
         prev_q <= sync_q[SYNC_STAGES-1];
      end
   end

   assign cur  = sync_q[SYNC_STAGES-1];
   assign rise = cur & ~prev_q;
   assign fall = ~cur & prev_q;

   always_comb begin
      unique case (sel)
         EDGE_FALL: edge_hit = enable & fall;
         EDGE_RISE: edge_hit = enable & rise;
         EDGE_BOTH: edge_hit = enable & (rise | fall);
         default:   edge_hit = 1'b0;
      endcase
   end

endmodule

// File: rtl/evt_count_core.sv
module evt_count_core #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             step,
   input  logic             clear,
   input  logic             wrap_on_cmp,
   input  logic [CNT_W-1:0] cmp0,
   input  logic             ovf_clr_req,
   output logic [CNT_W-1:0] cnt,
   output logic             ovf,
   output logic             ovf_hold
);

   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   logic at_max;
   logic wrap_now;
   logic ovf_set;
   logic live_step;

   assign live_step = run & step & ~clear;
   assign at_max    = (cnt == CNT_MAX);
   assign wrap_now  = wrap_on_cmp & (cnt == cmp0);
   assign ovf_set   = live_step & at_max;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (!run || clear) begin
         cnt <= '0;
      end else if (step) begin
         cnt <= wrap_now ? '0 : cnt + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ovf      <= 1'b0;
         ovf_hold <= 1'b0;
      end else begin
         if (ovf_set) begin
            ovf <= 1'b1;
         end else if (ovf_clr_req && !ovf_hold) begin
            ovf <= 1'b0;
         end

         if (ovf_set) begin
            ovf_hold <= 1'b1;
         end else if (!run || (run && step)) begin
            ovf_hold <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/evt_oneshot.sv
module evt_oneshot (
   input  logic clk,
   input  logic rst_n,
   input  logic allow,
   input  logic start_req,
   input  logic hit0,
   input  logic hit1,
   output logic busy,
   output logic pulse,
   output logic accept
);

   assign accept = allow & start_req & ~busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy  <= 1'b0;
         pulse <= 1'b0;
      end else if (!allow) begin
         busy  <= 1'b0;
         pulse <= 1'b0;
      end else if (accept) begin
         busy  <= 1'b1;
         pulse <= 1'b0;
      end else if (busy) begin
         if (hit0) begin
            busy  <= 1'b0;
            pulse <= 1'b0;
         end else if (hit1) begin
            pulse <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/evt_timer16.sv
module evt_timer16
   import evt_timer16_pkg::*;
#(
   parameter int               CNT_W           = 16,
   parameter int               SYNC_STAGES     = 2,
   parameter bit               RD_CONFLICT_X   = 1'b0,
   parameter logic [CNT_W-1:0] RD_CONFLICT_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bus_we,
   input  logic             bus_re,
   input  logic [1:0]       bus_addr,
   input  logic [CNT_W-1:0] bus_wdata,
   output logic [CNT_W-1:0] bus_rdata,
   input  logic             count_en,
   input  logic             trig_in,
   input  logic             cap_in,
   output logic             tmr_out,
   output logic             irq_cmp0,
   output logic             irq_cmp1,
   output logic             ovf_flag
);

   generate
      if (CNT_W < CTRL_BITS) begin : g_bad_width
         $error("evt_timer16: CNT_W too small for the control register");
      end
   endgenerate

   tmr_mode_e        mode_q;
   edge_sel_e        tsel_q;
   edge_sel_e        csel_q;
   logic             os_en_q;
   logic             cap_en_q;
   logic [CNT_W-1:0] cmp0_q;
   logic [CNT_W-1:0] cmp1_q;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] rdata_q;
   logic [CNT_W-1:0] ctrl_rd;
   logic [CNT_W-1:0] conflict_val;
   logic             irq0_q;
   logic             irq1_q;

   logic running;
   logic wr_ctrl;
   logic sw_trig;
   logic ovf_clr;
   logic trig_edge;
   logic cap_edge;
   logic count_step;
   logic hit0;
   logic hit1;
   logic os_allow;
   logic os_busy;
   logic os_pulse;
   logic os_accept;
   logic edge_clear;
   logic cnt_clear;
   logic cap_event;
   logic rd_conflict;
   logic ovf_hold;

   assign running    = (mode_q != MODE_STOP);
   assign wr_ctrl    = bus_we & (bus_addr == REG_CTRL);
   assign sw_trig    = wr_ctrl & bus_wdata[CB_SWTRIG];
   assign ovf_clr    = wr_ctrl & bus_wdata[CB_OVF];
   assign count_step = running & count_en;
   assign hit0       = count_step & (cnt_q == cmp0_q);
   assign hit1       = count_step & (cnt_q == cmp1_q);
   assign os_allow   = os_en_q & ((mode_q == MODE_FREE) | (mode_q == MODE_EDGE));
   assign edge_clear = (mode_q == MODE_EDGE) & trig_edge & ~os_busy;
   assign cnt_clear  = edge_clear | os_accept;
   assign cap_event  = cap_en_q & cap_edge;
   assign rd_conflict = bus_re & (bus_addr == REG_CMP1) & cap_event;

   evt_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_trig_det (
      .clk      (clk),
      .rst_n    (rst_n),
      .din      (trig_in),
      .sel      (tsel_q),
      .enable   (running),
      .edge_hit (trig_edge)
   );

   evt_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_cap_det (
      .clk      (clk),
      .rst_n    (rst_n),
      .din      (cap_in),
      .sel      (csel_q),
      .enable   (running),
      .edge_hit (cap_edge)
   );

   evt_count_core #(.CNT_W(CNT_W)) u_core (
      .clk         (clk),
      .rst_n       (rst_n),
      .run         (running),
      .step        (count_en),
      .clear       (cnt_clear),
      .wrap_on_cmp (mode_q == MODE_MATCH),
      .cmp0        (cmp0_q),
      .ovf_clr_req (ovf_clr),
      .cnt         (cnt_q),
      .ovf         (ovf_flag),
      .ovf_hold    (ovf_hold)
   );

   evt_oneshot u_os (
      .clk       (clk),
      .rst_n     (rst_n),
      .allow     (os_allow),
      .start_req (sw_trig | trig_edge),
      .hit0      (hit0),
      .hit1      (hit1),
      .busy      (os_busy),
      .pulse     (os_pulse),
      .accept    (os_accept)
   );

   // control register; edge selects only move while stopped
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q   <= MODE_STOP;
         tsel_q   <= EDGE_FALL;
         csel_q   <= EDGE_FALL;
         os_en_q  <= 1'b0;
         cap_en_q <= 1'b0;
      end else if (wr_ctrl) begin
         mode_q   <= tmr_mode_e'(bus_wdata[CB_MODE_LO +: 2]);
         os_en_q  <= bus_wdata[CB_OS_EN];
         cap_en_q <= bus_wdata[CB_CAP_EN];
         if (mode_q == MODE_STOP) begin
            tsel_q <= edge_sel_e'(bus_wdata[CB_TSEL_LO +: 2]);
            csel_q <= edge_sel_e'(bus_wdata[CB_CSEL_LO +: 2]);
         end
      end
   end

   // compare registers; capture outranks a bus write
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmp0_q <= '0;
         cmp1_q <= '0;
      end else begin
         if (bus_we && bus_addr == REG_CMP0) begin
            cmp0_q <= bus_wdata;
         end
         if (cap_event) begin
            cmp1_q <= cnt_q;
         end else if (bus_we && bus_addr == REG_CMP1) begin
            cmp1_q <= bus_wdata;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq0_q <= 1'b0;
         irq1_q <= 1'b0;
      end else begin
         irq0_q <= hit0;
         irq1_q <= hit1;
      end
   end

   generate
      if (RD_CONFLICT_X) begin : g_conf_x
         assign conflict_val = 'x;
      end else begin : g_conf_fixed
         assign conflict_val = RD_CONFLICT_VAL;
      end
   endgenerate

   always_comb begin
      ctrl_rd                     = '0;
      ctrl_rd[CB_MODE_LO +: 2]    = mode_q;
      ctrl_rd[CB_TSEL_LO +: 2]    = tsel_q;
      ctrl_rd[CB_CSEL_LO +: 2]    = csel_q;
      ctrl_rd[CB_OS_EN]           = os_en_q;
      ctrl_rd[CB_CAP_EN]          = cap_en_q;
      ctrl_rd[CB_OVF]             = ovf_flag;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata_q <= '0;
      end else if (bus_re) begin
         if (rd_conflict) begin
            rdata_q <= conflict_val;
         end else begin
            unique case (bus_addr)
               REG_CTRL: rdata_q <= ctrl_rd;
               REG_CNT:  rdata_q <= cnt_q;
               REG_CMP0: rdata_q <= cmp0_q;
               default:  rdata_q <= cmp1_q;
            endcase
         end
      end
   end

   assign bus_rdata = rdata_q;
   assign tmr_out   = os_pulse;
   assign irq_cmp0  = irq0_q;
   assign irq_cmp1  = irq1_q;

endmodule

// File: rtl/evt_timer16_chk.sv
module evt_timer16_chk #(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic [1:0]       mode,
   input logic [CNT_W-1:0] cnt,
   input logic             count_step,
   input logic             cnt_clear,
   input logic             ovf,
   input logic             ovf_hold,
   input logic             os_busy,
   input logic             tmr_out,
   input logic             irq_cmp0,
   input logic             hit0
);

   localparam logic [CNT_W-1:0] CMAX = '1;

   assert_stop_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'b00) |=> (cnt == '0));

   assert_match_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'b10 && hit0) |=> (cnt == '0 && irq_cmp0));

   assert_ovf_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (count_step && !cnt_clear && cnt == CMAX) |=> ovf);

   assert_ovf_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf && ovf_hold) |=> ovf);

   assert_pulse_in_shot_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tmr_out) |-> os_busy);

   assert_no_shot_match_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'b10) |=> !tmr_out);

endmodule

bind evt_timer16 evt_timer16_chk #(.CNT_W(CNT_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .mode       (mode_q),
   .cnt        (cnt_q),
   .count_step (count_step),
   .cnt_clear  (cnt_clear),
   .ovf        (ovf_flag),
   .ovf_hold   (ovf_hold),
   .os_busy    (os_busy),
   .tmr_out    (tmr_out),
   .irq_cmp0   (irq_cmp0),
   .hit0       (hit0)
);

// File: tb/tb_evt_timer16.sv
module tb_evt_timer16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_we = 1'b0;
   logic        bus_re = 1'b0;
   logic [1:0]  bus_addr = 2'd0;
   logic [15:0] bus_wdata = 16'd0;
   logic [15:0] bus_rdata;
   logic        count_en = 1'b0;
   logic        trig_in = 1'b0;
   logic        cap_in = 1'b0;
   logic        tmr_out;
   logic        irq_cmp0;
   logic        irq_cmp1;
   logic        ovf_flag;

   int n_chk = 0;
   int n_err = 0;

   always #2 clk = ~clk;

   evt_timer16 dut (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_re(bus_re),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .count_en(count_en), .trig_in(trig_in), .cap_in(cap_in),
      .tmr_out(tmr_out), .irq_cmp0(irq_cmp0), .irq_cmp1(irq_cmp1),
      .ovf_flag(ovf_flag)
   );

   // one-shot cases: {mode, cmp1, cmp0, expected width}
   localparam int OS_N = 4;
   localparam logic [49:0] OS_TAB [OS_N] = '{
      {2'b01, 16'd2, 16'd5,  16'd3},
      {2'b01, 16'd1, 16'd9,  16'd8},
      {2'b11, 16'd4, 16'd6,  16'd2},
      {2'b01, 16'd0, 16'd1,  16'd1}
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [15:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_we = 1'b1;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [15:0] d);
      @(negedge clk);
      bus_addr = a; bus_re = 1'b1;
      @(negedge clk);
      bus_re = 1'b0;
      d = bus_rdata;
   endtask

   task automatic steps(input int n);
      @(negedge clk);
      count_en = 1'b1;
      repeat (n) @(negedge clk);
      count_en = 1'b0;
   endtask

   task automatic settle();
      repeat (5) @(negedge clk);
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      logic [15:0] d;
      int hi, p1, first, second, n;

      repeat (5) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      rd(2'd0, d); check("R1 ctrl after reset", d, 16'h0000);
      rd(2'd3, d); check("R1 cmp1 after reset", d, 16'h0000);
      check("R1 outputs after reset", {tmr_out, irq_cmp0, irq_cmp1, ovf_flag}, 4'b0000);
      steps(5);
      rd(2'd1, d); check("R1 stopped counter holds 0", d, 16'h0000);

      // R2 free-running, no wrap at cmp0
      wr(2'd2, 16'd10);
      wr(2'd0, 16'h0001);
      steps(25);
      rd(2'd1, d); check("R2 free count", d, 16'd25);

      // R3 match-clear period
      wr(2'd0, 16'h0000);
      wr(2'd2, 16'd7);
      wr(2'd0, 16'h0002);
      @(negedge clk); count_en = 1'b1;
      first = -1; second = -1;
      for (int i = 0; i < 40; i++) begin
         @(negedge clk);
         if (irq_cmp0) begin
            if (first < 0) first = i;
            else if (second < 0) second = i;
         end
      end
      count_en = 1'b0;
      check("R3 match period", second - first, 32'd8);

      // table-driven one-shot widths (R8)
      for (int k = 0; k < OS_N; k++) begin
         logic [49:0] e;
         e = OS_TAB[k];
         wr(2'd0, 16'h0000);
         wr(2'd2, e[31:16]);
         wr(2'd3, e[47:32]);
         wr(2'd0, {14'd0, e[49:48]} | 16'h0040);
         count_en = 1'b1;
         wr(2'd0, {14'd0, e[49:48]} | 16'h0240);
         hi = 0; p1 = 0;
         for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (tmr_out) hi++;
            if (irq_cmp1) p1++;
         end
         count_en = 1'b0;
         check("R8 one-shot width", hi, {16'd0, e[15:0]});
         check("R8 irq_cmp1 pulses", p1, 32'd1);
      end

      // R9 retrigger during pulse
      wr(2'd0, 16'h0000);
      wr(2'd2, 16'd10);
      wr(2'd3, 16'd2);
      wr(2'd0, 16'h0041);
      count_en = 1'b1;
      wr(2'd0, 16'h0241);
      hi = 0;
      for (int i = 0; i < 100; i++) begin
         @(negedge clk);
         if (i == 4) begin bus_addr = 2'd0; bus_wdata = 16'h0241; bus_we = 1'b1; end
         if (i == 5) bus_we = 1'b0;
         if (tmr_out) hi++;
      end
      count_en = 1'b0;
      check("R9 retrigger ignored", hi, 32'd8);

      // R10 one-shot blocked in match-clear
      wr(2'd0, 16'h0000);
      wr(2'd2, 16'd20);
      wr(2'd3, 16'd3);
      wr(2'd0, 16'h0042);
      count_en = 1'b1;
      wr(2'd0, 16'h0242);
      hi = 0;
      for (int i = 0; i < 60; i++) begin
         @(negedge clk);
         if (tmr_out) hi++;
      end
      count_en = 1'b0;
      check("R10 no pulse in match mode", hi, 32'd0);

      // R6 edge-clear, rising select (01)
      wr(2'd0, 16'h0000);
      wr(2'd0, 16'h0004);
      wr(2'd0, 16'h0007);
      steps(10);
      rd(2'd1, d); check("R6 count before edge", d, 16'd10);
      trig_in = 1'b1; settle();
      rd(2'd1, d); check("R6 rising edge clears", d, 16'd0);
      steps(6);
      trig_in = 1'b0; settle();
      rd(2'd1, d); check("R6 falling ignored with rising select", d, 16'd6);

      // R7 edge select locked while running
      wr(2'd0, 16'h000F);
      rd(2'd0, d); check("R7 select unchanged while running", d[3:2], 2'b01);

      // R6 both edges (11)
      wr(2'd0, 16'h0000);
      wr(2'd0, 16'h000C);
      wr(2'd0, 16'h000F);
      steps(4);
      trig_in = 1'b1; settle();
      rd(2'd1, d); check("R6 both: rise clears", d, 16'd0);
      steps(4);
      trig_in = 1'b0; settle();
      rd(2'd1, d); check("R6 both: fall clears", d, 16'd0);

      // R6 reserved (10) gives no edge
      wr(2'd0, 16'h0000);
      wr(2'd0, 16'h0008);
      wr(2'd0, 16'h000B);
      steps(5);
      trig_in = 1'b1; settle();
      rd(2'd1, d); check("R6 reserved select no clear", d, 16'd5);
      trig_in = 1'b0; settle();

      // R11 capture on rising cap_in
      wr(2'd0, 16'h0000);
      wr(2'd0, 16'h0090);
      wr(2'd0, 16'h0091);
      steps(9);
      cap_in = 1'b1; settle();
      rd(2'd3, d); check("R11 capture value", d, 16'd9);
      cap_in = 1'b0; settle();

      // R12 counter read does not capture
      steps(3);
      rd(2'd1, d); check("R12 counter read", d, 16'd12);
      rd(2'd3, d); check("R12 cmp1 unchanged by counter read", d, 16'd9);

      // R13 capture and read in the same cycle
      steps(2);
      @(negedge clk); cap_in = 1'b1;
      @(posedge clk); @(posedge clk);
      @(negedge clk); bus_addr = 2'd3; bus_re = 1'b1;
      @(negedge clk); bus_re = 1'b0;
      check("R13 conflicting read value", bus_rdata, 16'h0000);
      rd(2'd3, d); check("R13 capture wins", d, 16'd14);

      // R14 stopped: no capture, no trigger
      wr(2'd0, 16'h0090);
      cap_in = 1'b0; settle();
      cap_in = 1'b1; settle();
      rd(2'd3, d); check("R14 no capture while stopped", d, 16'd14);
      wr(2'd0, 16'h0041);
      count_en = 1'b0;
      wr(2'd0, 16'h0000);
      trig_in = 1'b1; settle();
      trig_in = 1'b0; settle();
      check("R14 no pulse from trigger while stopped", tmr_out, 1'b0);

      // R4 overflow in match-clear with cmp0 = FFFFH, then R5 hold
      wr(2'd2, 16'hFFFF);
      wr(2'd0, 16'h0002);
      count_en = 1'b1;
      n = 0;
      while (!ovf_flag && n < 70000) begin
         @(negedge clk);
         n++;
      end
      count_en = 1'b0;
      check("R4 overflow in match mode after 65536 steps", n, 32'd65536);
      wr(2'd0, 16'h0102);
      rd(2'd0, d); check("R5 clear before next step is dropped", d[8], 1'b1);
      steps(1);
      wr(2'd0, 16'h0102);
      @(negedge clk);
      check("R5 clear after a step takes effect", ovf_flag, 1'b0);

      // R4 overflow in free-running mode
      wr(2'd0, 16'h0000);
      wr(2'd0, 16'h0001);
      count_en = 1'b1;
      n = 0;
      while (!ovf_flag && n < 70000) begin
         @(negedge clk);
         n++;
      end
      count_en = 1'b0;
      check("R4 overflow in free mode after 65536 steps", n, 32'd65536);

      finish_run();
   end

endmodule